// File: doc/BRIEF.md
# Load-Use Interlock and Operand Bypass Controller

This block is the hazard controller for an in-order five-stage pipeline with fetch, decode, execute, memory and writeback stages. Each cycle it compares the source specifiers of the instruction in decode with the destinations of the two instructions ahead of it. It decides whether decode must hold for one cycle because a load result is not ready yet. It also decides which bypass path each operand of that instruction will use once it reaches execute.

The stall and bubble outputs are combinational, because fetch and decode must freeze in the same cycle that the hazard is seen. The forwarding selects are worked out while the instruction is still in decode. They are registered on the edge that moves it into execute, so the datapath multiplexers get a clean flop output. The store-data bypass flag is carried one stage further and is presented while the store sits in the memory stage.

A store whose only dependency on the load just ahead of it is its data operand is not stalled. The loaded word is instead bypassed from writeback into the memory stage. The register file is assumed to write before it reads within a cycle, so no bypass from the retiring instruction is needed.

Top module: `ldu_hazard_ctl`

## Requirements
- R1: Instruction classes are coded on 2 bits: 0 ALU, 1 branch-if-zero, 2 load, 3 store. When execute holds a load (class 2, write enable high, destination non-zero), `stall` is high in that same cycle if decode has its first-source enable set and its first source equals that destination. This applies to every class in decode, including a store's address base.
- R2: Under the same load condition, `stall` is high if decode has its second-source enable set and its second source equals the load destination, provided the decode instruction is not a store.
- R3: A store whose second source (data) matches a load in execute, and whose first source does not match, causes no stall. `st_fwd` is then high for exactly the cycle in which that store occupies the memory stage, and low in all other cycles.
- R4: A source whose enable is low never causes a stall or a bypass. Register 0 never matches as a producer.
- R5: `bubble` equals `stall` in every cycle. A load-use hazard costs exactly one stall cycle, after which the dependent instruction advances.
- R6: `fwd_a` and `fwd_b` give the source of the first and second operand of the instruction currently in execute: 0 register file, 1 memory-stage result, 2 writeback-stage result. When both later stages write the register, the memory stage wins.
- R7: Memory-stage bypass (code 1) is selected only when that producer is an ALU operation. A load in the memory stage yields code 0 for a matching operand, even if an older writer of the same register is in writeback.
- R8: Synchronous active-high reset drives `fwd_a`, `fwd_b` and `st_fwd` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| d_rs1 | input | AW | Decode first source register |
| d_rs2 | input | AW | Decode second source register |
| d_re1 | input | 1 | Decode first source is read |
| d_re2 | input | 1 | Decode second source is read |
| d_cls | input | 2 | Decode instruction class |
| x_rd | input | AW | Execute destination register |
| x_wen | input | 1 | Execute instruction writes a register |
| x_cls | input | 2 | Execute instruction class |
| m_rd | input | AW | Memory-stage destination register |
| m_wen | input | 1 | Memory-stage instruction writes a register |
| m_cls | input | 2 | Memory-stage instruction class |
| stall | output | 1 | Hold fetch and decode this cycle |
| bubble | output | 1 | Load an empty instruction into execute on this edge |
| fwd_a | output | 2 | First ALU operand source for the instruction in execute |
| fwd_b | output | 2 | Second ALU operand source for the instruction in execute |
| st_fwd | output | 1 | Replace store data in the memory stage with the writeback value |

## Verification
A short program is run through a behavioural pipeline model. Back-to-back ALU producers show the memory-stage bypass and its priority over writeback. A producer two slots back shows the writeback bypass. Load-then-use pairs are aimed at the first operand, the second operand, a store base and a branch, which shows that each of them costs one stall. A load followed by a store on the data operand alone shows the no-stall path with the late store bypass. Loads into register 0, disabled source fields, and a load that shadows an older ALU writer of the same register show that false matches and the wrong bypass choice are suppressed.

// File: rtl/ldu_hz_pkg.sv
package ldu_hz_pkg;
  typedef enum logic [1:0] {
    CLS_ALU   = 2'd0,
    CLS_BEQZ  = 2'd1,
    CLS_LOAD  = 2'd2,
    CLS_STORE = 2'd3
  } icls_e;

  typedef enum logic [1:0] {
    SRC_RF  = 2'd0,
    SRC_MEM = 2'd1,
    SRC_WB  = 2'd2
  } fsel_e;
endpackage

// File: rtl/ldu_load_cmp.sv
module ldu_load_cmp
  import ldu_hz_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] d_rs1,
  input  logic [AW-1:0] d_rs2,
  input  logic          d_re1,
  input  logic          d_re2,
  input  logic [1:0]    d_cls,
  input  logic [AW-1:0] x_rd,
  input  logic          x_wen,
  input  logic [1:0]    x_cls,
  output logic          stall,
  output logic          st_hit
);
  logic x_is_ld;
  logic hit_base;
  logic hit_data;
  logic d_is_st;

  // a load in execute whose result is still in flight
  assign x_is_ld  = x_wen && (x_cls == CLS_LOAD) && (x_rd != '0);
  assign d_is_st  = (d_cls == CLS_STORE);
  assign hit_base = d_re1 && (d_rs1 == x_rd);
  assign hit_data = d_re2 && (d_rs2 == x_rd);

  // store data is picked up late, in the memory stage
  assign stall  = x_is_ld && (hit_base || (hit_data && !d_is_st));
  assign st_hit = x_is_ld && hit_data && d_is_st && !hit_base;

  // R5
  stall_single_chk: assert property (@(posedge clk) disable iff (rst)
    stall |=> !stall);

  // R3
  st_no_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (d_is_st && d_re1 && (d_rs1 != x_rd)) |-> !stall);
endmodule

// File: rtl/ldu_fwd_pick.sv
module ldu_fwd_pick
  import ldu_hz_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic [AW-1:0] rs,
  input  logic          re,
  input  logic [AW-1:0] x_rd,
  input  logic          x_wen,
  input  logic [1:0]    x_cls,
  input  logic [AW-1:0] m_rd,
  input  logic          m_wen,
  output logic [1:0]    sel
);
  logic near_hit;
  logic far_hit;

  // producers seen from decode: execute becomes memory, memory becomes writeback
  assign near_hit = re && x_wen && (x_rd != '0) && (x_rd == rs);
  assign far_hit  = re && m_wen && (m_rd != '0) && (m_rd == rs);

  always_comb begin
    if (near_hit) begin
      sel = (x_cls == CLS_ALU) ? SRC_MEM : SRC_RF;
    end else if (far_hit) begin
      sel = SRC_WB;
    end else begin
      sel = SRC_RF;
    end
  end
endmodule

// File: rtl/ldu_store_fwd.sv
module ldu_store_fwd #(
  parameter int LAG = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic hit,
  input  logic hold,
  output logic st_fwd
);
  logic [LAG-1:0] pipe_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pipe_q <= '0;
    end else begin
      pipe_q[0] <= hit && !hold;
      for (int i = 1; i < LAG; i++) begin
        pipe_q[i] <= pipe_q[i-1];
      end
    end
  end

  assign st_fwd = pipe_q[LAG-1];
endmodule

// File: rtl/ldu_hazard_ctl.sv
module ldu_hazard_ctl
  import ldu_hz_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] d_rs1,
  input  logic [AW-1:0] d_rs2,
  input  logic          d_re1,
  input  logic          d_re2,
  input  logic [1:0]    d_cls,
  input  logic [AW-1:0] x_rd,
  input  logic          x_wen,
  input  logic [1:0]    x_cls,
  input  logic [AW-1:0] m_rd,
  input  logic          m_wen,
  input  logic [1:0]    m_cls,
  output logic          stall,
  output logic          bubble,
  output logic [1:0]    fwd_a,
  output logic [1:0]    fwd_b,
  output logic          st_fwd
);
  localparam int NOPS = 2;
  localparam int ST_LAG = 2;

  logic          st_hit;
  logic [AW-1:0] src_v [NOPS];
  logic          ren_v [NOPS];
  logic [1:0]    sel_v [NOPS];
  logic [1:0]    fwd_q [NOPS];

  assign src_v[0] = d_rs1;
  assign src_v[1] = d_rs2;
  assign ren_v[0] = d_re1;
  assign ren_v[1] = d_re2;

  ldu_load_cmp #(.AW(AW)) u_cmp (
    .clk   (clk),
    .rst   (rst),
    .d_rs1 (d_rs1),
    .d_rs2 (d_rs2),
    .d_re1 (d_re1),
    .d_re2 (d_re2),
    .d_cls (d_cls),
    .x_rd  (x_rd),
    .x_wen (x_wen),
    .x_cls (x_cls),
    .stall (stall),
    .st_hit(st_hit)
  );

  assign bubble = stall;

  for (genvar g = 0; g < NOPS; g++) begin : g_op
    ldu_fwd_pick #(.AW(AW)) u_pick (
      .rs    (src_v[g]),
      .re    (ren_v[g]),
      .x_rd  (x_rd),
      .x_wen (x_wen),
      .x_cls (x_cls),
      .m_rd  (m_rd),
      .m_wen (m_wen),
      .sel   (sel_v[g])
    );

    // the bubble entering execute reads nothing
    always_ff @(posedge clk) begin
      if (rst || stall) begin
        fwd_q[g] <= SRC_RF;
      end else begin
        fwd_q[g] <= sel_v[g];
      end
    end

    // R7
    mem_src_alu_chk: assert property (@(posedge clk) disable iff (rst)
      (fwd_q[g] == SRC_MEM) |-> ($past(x_cls) == CLS_ALU));
  end

  assign fwd_a = fwd_q[0];
  assign fwd_b = fwd_q[1];

  ldu_store_fwd #(.LAG(ST_LAG)) u_stf (
    .clk   (clk),
    .rst   (rst),
    .hit   (st_hit),
    .hold  (stall),
    .st_fwd(st_fwd)
  );

  // R3
  st_in_mem_chk: assert property (@(posedge clk) disable iff (rst)
    st_fwd |-> (m_cls == CLS_STORE));

  // R4
  zero_never_chk: assert property (@(posedge clk) disable iff (rst)
    ((d_rs1 == '0) && (d_rs2 == '0)) |-> !stall);

  // R8
  rst_clear_chk: assert property (@(posedge clk)
    rst |=> ((fwd_a == 2'd0) && (fwd_b == 2'd0) && !st_fwd));
endmodule

// File: tb/ldu_hazard_ctl_tb.sv
module ldu_hazard_ctl_tb;
  localparam int NPROG = 24;

  typedef struct {
    int         idx;
    logic [1:0] cls;
    logic [4:0] rd;
    logic [4:0] rs1;
    logic [4:0] rs2;
    logic       re1;
    logic       re2;
    logic       we;
  } ins_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] d_rs1, d_rs2, x_rd, m_rd;
  logic       d_re1, d_re2, x_wen, m_wen;
  logic [1:0] d_cls, x_cls, m_cls;
  logic       stall, bubble, st_fwd;
  logic [1:0] fwd_a, fwd_b;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  ins_t prog [NPROG];
  ins_t s_d, s_x, s_m, s_w;
  int   pc = 0;
  int   obs_stall [NPROG];
  int   obs_fa [NPROG];
  int   obs_fb [NPROG];
  int   obs_st [NPROG];
  int   stall_total = 0;

  always #10 clk = ~clk;

  ldu_hazard_ctl #(.AW(5)) u_dut (
    .clk(clk), .rst(rst),
    .d_rs1(d_rs1), .d_rs2(d_rs2), .d_re1(d_re1), .d_re2(d_re2), .d_cls(d_cls),
    .x_rd(x_rd), .x_wen(x_wen), .x_cls(x_cls),
    .m_rd(m_rd), .m_wen(m_wen), .m_cls(m_cls),
    .stall(stall), .bubble(bubble), .fwd_a(fwd_a), .fwd_b(fwd_b), .st_fwd(st_fwd)
  );

  function automatic ins_t nop();
    ins_t t;
    t.idx = -1; t.cls = 2'd0; t.rd = 5'd0; t.rs1 = 5'd0; t.rs2 = 5'd0;
    t.re1 = 1'b0; t.re2 = 1'b0; t.we = 1'b0;
    return t;
  endfunction

  function automatic ins_t mk(int i, logic [1:0] c, int rd, int a, int b,
                              logic ra, logic rb, logic w);
    ins_t t;
    t.idx = i; t.cls = c; t.rd = 5'(rd); t.rs1 = 5'(a); t.rs2 = 5'(b);
    t.re1 = ra; t.re2 = rb; t.we = w;
    return t;
  endfunction

  // behavioural view: where does a consumer now in execute get operand r?
  function automatic int src_of(logic en, logic [4:0] r);
    if (!en) return 0;
    if (s_m.we && s_m.rd != 0 && s_m.rd == r) return (s_m.cls == 2'd0) ? 1 : 0;
    if (s_w.we && s_w.rd != 0 && s_w.rd == r) return 2;
    return 0;
  endfunction

  function automatic int want_stall();
    if (!(s_x.cls == 2'd2 && s_x.we && s_x.rd != 0)) return 0;
    if (s_d.re1 && s_d.rs1 == s_x.rd) return 1;
    if (s_d.re2 && s_d.rs2 == s_x.rd && s_d.cls != 2'd3) return 1;
    return 0;
  endfunction

  function automatic int want_st();
    if (s_m.cls == 2'd3 && s_m.re2 && s_w.cls == 2'd2 && s_w.we &&
        s_w.rd != 0 && s_w.rd == s_m.rs2) return 1;
    return 0;
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic drive();
    d_rs1 = s_d.rs1; d_rs2 = s_d.rs2; d_re1 = s_d.re1; d_re2 = s_d.re2; d_cls = s_d.cls;
    x_rd = s_x.rd; x_wen = s_x.we; x_cls = s_x.cls;
    m_rd = s_m.rd; m_wen = s_m.we; m_cls = s_m.cls;
  endtask

  initial begin
    // classes: 0 ALU, 1 branch-if-zero, 2 load, 3 store
    prog[0]  = mk(0, 2'd0, 1, 2, 3, 1, 1, 1);
    prog[1]  = mk(1, 2'd0, 4, 1, 1, 1, 1, 1);
    prog[2]  = mk(2, 2'd0, 5, 1, 4, 1, 1, 1);
    prog[3]  = mk(3, 2'd2, 6, 2, 0, 1, 0, 1);
    prog[4]  = mk(4, 2'd0, 7, 3, 6, 1, 1, 1);
    prog[5]  = mk(5, 2'd2, 8, 2, 0, 1, 0, 1);
    prog[6]  = mk(6, 2'd3, 0, 3, 8, 1, 1, 0);
    prog[7]  = mk(7, 2'd2, 9, 2, 0, 1, 0, 1);
    prog[8]  = mk(8, 2'd3, 0, 9, 3, 1, 1, 0);
    prog[9]  = mk(9, 2'd2, 0, 2, 0, 1, 0, 1);
    prog[10] = mk(10, 2'd0, 11, 0, 0, 1, 1, 1);
    prog[11] = mk(11, 2'd2, 12, 2, 0, 1, 0, 1);
    prog[12] = mk(12, 2'd1, 0, 3, 12, 1, 0, 0);
    prog[13] = mk(13, 2'd2, 14, 2, 0, 1, 0, 1);
    prog[14] = mk(14, 2'd1, 0, 14, 0, 1, 0, 0);
    prog[15] = mk(15, 2'd0, 15, 2, 3, 1, 1, 1);
    prog[16] = mk(16, 2'd0, 15, 15, 3, 1, 1, 1);
    prog[17] = mk(17, 2'd0, 16, 15, 15, 1, 1, 1);
    prog[18] = mk(18, 2'd2, 17, 2, 0, 1, 0, 1);
    prog[19] = mk(19, 2'd0, 18, 3, 3, 1, 1, 1);
    prog[20] = mk(20, 2'd0, 19, 17, 18, 1, 1, 1);
    prog[21] = mk(21, 2'd0, 20, 2, 3, 1, 1, 1);
    prog[22] = mk(22, 2'd2, 20, 2, 0, 1, 0, 1);
    prog[23] = mk(23, 2'd3, 0, 3, 20, 1, 1, 0);
    for (int i = 0; i < NPROG; i++) begin
      obs_stall[i] = 0; obs_fa[i] = -1; obs_fb[i] = -1; obs_st[i] = 0;
    end

    s_d = nop(); s_x = nop(); s_m = nop(); s_w = nop();
    drive();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R8", "fwd_a after reset", int'(fwd_a), 0);
    chk("R8", "fwd_b after reset", int'(fwd_b), 0);
    chk("R8", "st_fwd after reset", int'(st_fwd), 0);

    for (int cyc = 0; cyc < 36; cyc++) begin
      int es;
      drive();
      #1;
      es = want_stall();
      chk("R1", "stall", int'(stall), es);
      chk("R5", "bubble", int'(bubble), es);
      chk("R6", "fwd_a", int'(fwd_a), src_of(s_x.re1, s_x.rs1));
      chk("R6", "fwd_b", int'(fwd_b), src_of(s_x.re2, s_x.rs2));
      chk("R3", "st_fwd", int'(st_fwd), want_st());
      if (s_x.idx >= 0) begin
        obs_fa[s_x.idx] = int'(fwd_a);
        obs_fb[s_x.idx] = int'(fwd_b);
      end
      if (s_m.idx >= 0) obs_st[s_m.idx] = int'(st_fwd);
      if (stall) begin
        stall_total++;
        if (s_d.idx >= 0) obs_stall[s_d.idx]++;
      end
      s_w = s_m;
      s_m = s_x;
      if (es != 0) begin
        s_x = nop();
      end else begin
        s_x = s_d;
        if (pc < NPROG) begin
          s_d = prog[pc];
          pc++;
        end else begin
          s_d = nop();
        end
      end
      @(posedge clk);
      @(negedge clk);
    end

    // R6: bypass sources and memory-stage priority
    chk("R6", "i1 fwd_a", obs_fa[1], 1);
    chk("R6", "i1 fwd_b", obs_fb[1], 1);
    chk("R6", "i2 fwd_a", obs_fa[2], 2);
    chk("R6", "i2 fwd_b", obs_fb[2], 1);
    chk("R6", "i17 fwd_a priority", obs_fa[17], 1);
    // R2: second operand load-use
    chk("R2", "i4 stall cycles", obs_stall[4], 1);
    chk("R2", "i4 fwd_b", obs_fb[4], 2);
    // R1: store base and branch load-use
    chk("R1", "i8 stall cycles", obs_stall[8], 1);
    chk("R1", "i14 stall cycles", obs_stall[14], 1);
    // R3: store data bypass
    chk("R3", "i6 stall cycles", obs_stall[6], 0);
    chk("R3", "i6 st_fwd", obs_st[6], 1);
    chk("R3", "i23 st_fwd", obs_st[23], 1);
    chk("R3", "i8 st_fwd", obs_st[8], 0);
    // R4: register zero and disabled fields
    chk("R4", "i10 stall cycles", obs_stall[10], 0);
    chk("R4", "i10 fwd_a", obs_fa[10], 0);
    chk("R4", "i12 stall cycles", obs_stall[12], 0);
    // R7: loads are not bypassed from the memory stage
    chk("R7", "i23 fwd_b", obs_fb[23], 0);
    chk("R7", "i20 fwd_a", obs_fa[20], 2);
    chk("R7", "i20 fwd_b", obs_fb[20], 1);
    // R5: one cycle per hazard
    chk("R5", "total stall cycles", stall_total, 3);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule